// File: doc/BRIEF.md
# Deployment Inhibit Controller

This block holds a small satellite's electrical bus inhibits closed until the spacecraft has been ejected and has waited out a fixed settling time. Three timers race toward the release: two outside timers, each presenting a level that goes high once its own time has run out, and one internal counter started by this block. Release happens only when at least two of the three agree. At release the block drives three persistent latch outputs high: one for each of the two series bus relays and one auxiliary-bus keep-alive enable.

The remove-before-flight pin is watched throughout. Its level is first synchronized and then filtered, so that only a level held for a full debounce window counts. Seeing the pin inserted forces every latch off. Seeing it pulled again starts the internal countdown over from zero. The latches sit on the power-on reset alone. A watchdog reset of the controller logic therefore restarts the synchronizers, the filter, the counter and the state machine, but leaves the relays as they were.

Top module: `deploy_inhibit_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises, all three latch outputs are low until a release occurs.
- R2: `rbf_pin` (1 = pin inserted, 0 = pin removed) passes through a two-flop synchronizer. A new level is acted on only after it has held for `DEB_CYCLES` consecutive synchronized cycles. A shorter excursion has no effect on the outputs.
- R3: Release requires at least two of the three timer indications. The internal timer's expiry alone, or one outside timer alone, keeps all outputs low.
- R4: The internal timer counts `COUNT_CYCLES` clock cycles from entry to the countdown. Together with one outside timer high, release follows about `COUNT_CYCLES` plus the filter latency after the pin is pulled, and not before.
- R5: On release, `bus_relay_a_on`, `bus_relay_b_on` and `aux_keepalive_en` go high on the same clock edge, and the three always match.
- R6: A filtered pin-inserted level clears all three outputs on the next clock, in every state.
- R7: Pulling the pin after a re-insertion restarts the internal countdown from zero.
- R8: During the countdown the outputs stay low. After release they stay high whatever the outside timers do, until the pin is inserted.
- R9: A pulse on `wdt_rst_n` leaves the outputs unchanged, and the controller returns to the released state when the latches are on. A pulse on `por_n` clears them.
- R10: Both outside timers high release the relays as soon as the countdown starts, long before the internal timer expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low; clears the latches and the logic |
| wdt_rst_n | input | 1 | Watchdog reset, active low; clears the logic but not the latches |
| rbf_pin | input | 1 | Remove-before-flight sense, asynchronous; 1 = inserted |
| ext_tmr_a | input | 1 | First outside timer, asynchronous; 1 = expired |
| ext_tmr_b | input | 1 | Second outside timer, asynchronous; 1 = expired |
| bus_relay_a_on | output | 1 | Persistent latch for the first series bus relay |
| bus_relay_b_on | output | 1 | Persistent latch for the second series bus relay |
| aux_keepalive_en | output | 1 | Persistent auxiliary bus keep-alive enable |

## Verification
The hardest situation to reach is a pull of the pin after a re-insertion in the middle of a countdown. Only the output timing shows whether the counter restarted, so the stimulus removes the pin, waits half the countdown, re-inserts it, removes it again and then samples just before and just after a full countdown from the second pull. A watchdog pulse while released is the other case that is hard to see from outside: the bench fires it with both outside timers already low. Only the latch persistence can then keep the relays on, and the bench confirms that the state machine climbs back to the released state without a vote.

// File: rtl/dic_pkg.sv
package dic_pkg;

  typedef enum logic [1:0] {
    ST_IDLE_RBF  = 2'd0,
    ST_COUNTDOWN = 2'd1,
    ST_RELEASED  = 2'd2,
    ST_SAFE_OFF  = 2'd3
  } dic_state_e;

  // majority of three timer indications
  function automatic logic vote2of3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  // true when a stability count has reached its window
  function automatic logic window_full(input int unsigned cnt, input int unsigned win);
    return cnt == win;
  endfunction

endpackage

// File: rtl/dic_sync.sv
module dic_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int SHW = W * STAGES;

  logic [SHW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SHW-W-1:0], d};
  end

  assign q = sh[SHW-1 -: W];
endmodule

// File: rtl/dic_debounce.sv
module dic_debounce import dic_pkg::*; #(
  parameter int CYCLES = 327
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic steady_high,
  output logic steady_low
);
  localparam int AW = $clog2(CYCLES + 1);

  logic          last_q;
  logic [AW-1:0] age_q;
  logic          full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      age_q  <= '0;
    end else begin
      last_q <= d;
      if (d != last_q)              age_q <= '0;
      else if (age_q < AW'(CYCLES)) age_q <= age_q + 1'b1;
    end
  end

  assign full        = window_full(int'(age_q), CYCLES);
  assign steady_high = full & last_q;
  assign steady_low  = full & ~last_q;
endmodule

// File: rtl/dic_countdown.sv
module dic_countdown #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (run && !expired)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == CW'(CYCLES));
endmodule

// File: rtl/dic_latch_bank.sv
module dic_latch_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         set_all,
  input  logic         clr_all,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       q[g] <= 1'b0;
      else if (clr_all) q[g] <= 1'b0;
      else if (set_all) q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/deploy_inhibit_ctrl.sv
module deploy_inhibit_ctrl import dic_pkg::*; #(
  parameter int CLK_HZ       = 32768,
  parameter int COUNT_SEC    = 1800,
  parameter int DEBOUNCE_MS  = 10,
  parameter int SYNC_STAGES  = 2,
  parameter int COUNT_CYCLES = CLK_HZ * COUNT_SEC,
  parameter int DEB_CYCLES   = (CLK_HZ * DEBOUNCE_MS) / 1000
) (
  input  logic clk,
  input  logic por_n,
  input  logic wdt_rst_n,
  input  logic rbf_pin,
  input  logic ext_tmr_a,
  input  logic ext_tmr_b,
  output logic bus_relay_a_on,
  output logic bus_relay_b_on,
  output logic aux_keepalive_en
);
  localparam int NLATCH = 3;

  logic             lrst_n;
  logic [2:0]       raw_in, sync_q;
  logic             rbf_ins, rbf_rem;
  logic             int_done, vote;
  logic             cnt_restart, cnt_run;
  logic             lat_set, lat_clr, lat_on;
  logic [NLATCH-1:0] lat_q;
  dic_state_e       state_q, state_d;

  // logic reset: either source clears the controller, only por_n the latches
  assign lrst_n = por_n & wdt_rst_n;
  assign raw_in = {ext_tmr_b, ext_tmr_a, rbf_pin};

  dic_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(lrst_n), .d(raw_in), .q(sync_q)
  );

  dic_debounce #(.CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(lrst_n), .d(sync_q[0]),
    .steady_high(rbf_ins), .steady_low(rbf_rem)
  );

  dic_countdown #(.CYCLES(COUNT_CYCLES)) u_cnt (
    .clk(clk), .rst_n(lrst_n), .restart(cnt_restart), .run(cnt_run),
    .expired(int_done)
  );

  dic_latch_bank #(.N(NLATCH)) u_lat (
    .clk(clk), .por_n(por_n), .set_all(lat_set), .clr_all(lat_clr), .q(lat_q)
  );

  assign lat_on  = lat_q[0];
  assign vote    = vote2of3({int_done, sync_q[2], sync_q[1]});
  assign cnt_run = (state_q == ST_COUNTDOWN);

  always_comb begin
    state_d     = state_q;
    lat_set     = 1'b0;
    lat_clr     = 1'b0;
    cnt_restart = 1'b0;
    unique case (state_q)
      ST_IDLE_RBF: begin
        if (rbf_ins)      lat_clr = 1'b1;
        else if (lat_on)  state_d = ST_RELEASED;
        else if (rbf_rem) begin
          state_d     = ST_COUNTDOWN;
          cnt_restart = 1'b1;
        end
      end
      ST_COUNTDOWN: begin
        if (rbf_ins) begin
          state_d = ST_SAFE_OFF;
          lat_clr = 1'b1;
        end else if (vote) begin
          state_d = ST_RELEASED;
          lat_set = 1'b1;
        end else begin
          lat_clr = 1'b1;
        end
      end
      ST_RELEASED: begin
        if (rbf_ins) begin
          state_d = ST_SAFE_OFF;
          lat_clr = 1'b1;
        end
      end
      ST_SAFE_OFF: begin
        if (rbf_ins)      lat_clr = 1'b1;
        else if (rbf_rem) begin
          state_d     = ST_COUNTDOWN;
          cnt_restart = 1'b1;
        end
      end
      default: state_d = ST_IDLE_RBF;
    endcase
  end

  always_ff @(posedge clk or negedge lrst_n) begin
    if (!lrst_n) state_q <= ST_IDLE_RBF;
    else         state_q <= state_d;
  end

  assign bus_relay_a_on   = lat_q[0];
  assign bus_relay_b_on   = lat_q[1];
  assign aux_keepalive_en = lat_q[2];
endmodule

// File: rtl/dic_checker.sv
module dic_checker import dic_pkg::*; (
  input logic       clk,
  input logic       por_n,
  input logic       wdt_rst_n,
  input logic       rbf_in_w,
  input logic       vote_w,
  input dic_state_e st_w,
  input logic       relay_a,
  input logic       relay_b,
  input logic       keep
);
  p_outputs_match_r5: assert property (@(posedge clk) disable iff (!por_n)
    (relay_a == relay_b) && (relay_a == keep));

  p_rise_needs_vote_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(relay_a) |-> $past(vote_w));

  p_insert_clears_r6: assert property (@(posedge clk) disable iff (!por_n)
    rbf_in_w |=> (!relay_a && !relay_b && !keep));

  p_wdt_keeps_r9: assert property (@(posedge clk) disable iff (!por_n)
    !wdt_rst_n |=> $stable({relay_a, relay_b, keep}));

  p_release_holds_r8: assert property (@(posedge clk) disable iff (!por_n)
    (st_w == ST_RELEASED && !rbf_in_w && wdt_rst_n && relay_a) |=> relay_a);

  p_countdown_off_r8: assert property (@(posedge clk) disable iff (!por_n)
    (st_w == ST_COUNTDOWN && !vote_w && wdt_rst_n) |=> !relay_a);
endmodule

bind deploy_inhibit_ctrl dic_checker u_chk (
  .clk(clk), .por_n(por_n), .wdt_rst_n(wdt_rst_n), .rbf_in_w(rbf_ins),
  .vote_w(vote), .st_w(state_q), .relay_a(bus_relay_a_on),
  .relay_b(bus_relay_b_on), .keep(aux_keepalive_en)
);

// File: tb/sim_deploy_inhibit_ctrl.sv
`timescale 1ns/1ps
module sim_deploy_inhibit_ctrl;
  localparam int N   = 300;
  localparam int DEB = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0, wdt_rst_n = 1'b0;
  logic rbf_pin = 1'b1, ext_tmr_a = 1'b0, ext_tmr_b = 1'b0;
  logic ra, rb, ka;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  deploy_inhibit_ctrl #(.COUNT_CYCLES(N), .DEB_CYCLES(DEB)) u0 (
    .clk(clk), .por_n(por_n), .wdt_rst_n(wdt_rst_n), .rbf_pin(rbf_pin),
    .ext_tmr_a(ext_tmr_a), .ext_tmr_b(ext_tmr_b),
    .bus_relay_a_on(ra), .bus_relay_b_on(rb), .aux_keepalive_en(ka)
  );

  // behavioural reference: queues for synchronizer delay, integers for ages
  bit rq[$], aq[$], bq[$];
  int m_last, m_age, m_el, m_phase;  // phase 0 idle,1 counting,2 released,3 safe
  bit m_on;

  task automatic model_logic_reset();
    rq = '{0, 0}; aq = '{0, 0}; bq = '{0, 0};
    m_last = 0; m_age = 0; m_el = 0; m_phase = 0;
  endtask

  initial begin m_on = 1'b0; model_logic_reset(); end

  always @(posedge clk) begin
    bit ins, rem, enter;
    int votes, nph;
    cyc++;
    if (!por_n) begin
      m_on = 1'b0; model_logic_reset();
    end else if (!wdt_rst_n) begin
      model_logic_reset();
    end else begin
      ins   = (m_age == DEB) && (m_last == 1);
      rem   = (m_age == DEB) && (m_last == 0);
      votes = int'(m_el == N) + int'(aq[0]) + int'(bq[0]);
      nph = m_phase; enter = 1'b0;
      case (m_phase)
        0: if (ins) m_on = 0; else if (m_on) nph = 2; else if (rem) begin nph = 1; enter = 1; end
        1: if (ins) begin nph = 3; m_on = 0; end
           else if (votes >= 2) begin nph = 2; m_on = 1; end
           else m_on = 0;
        2: if (ins) begin nph = 3; m_on = 0; end
        default: if (ins) m_on = 0; else if (rem) begin nph = 1; enter = 1; end
      endcase
      if (enter) m_el = 0;
      else if (m_phase == 1 && m_el < N) m_el++;
      m_phase = nph;
      if (int'(rq[0]) != m_last) m_age = 0;
      else if (m_age < DEB) m_age++;
      m_last = int'(rq[0]);
      void'(rq.pop_front()); rq.push_back(rbf_pin);
      void'(aq.pop_front()); aq.push_back(ext_tmr_a);
      void'(bq.pop_front()); bq.push_back(ext_tmr_b);
    end
  end

  // every-cycle comparison with the reference
  always @(negedge clk) begin
    if (cmp_on) begin
      n_tests++;
      if ({ra, rb, ka} !== {3{m_on}}) begin
        n_fail++;
        $display("FAIL %s model cycle %0d: actual=%b expected=%b", cur_req, cyc,
                 {ra, rb, ka}, {3{m_on}});
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [2:0] exp);
    n_tests++;
    if ({ra, rb, ka} !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", tag, {ra, rb, ka}, exp);
    end
  endtask

  initial begin
    wait_cyc(3);
    chk("R1 during power-on reset", 3'b000);
    por_n = 1'b1; wdt_rst_n = 1'b1; cmp_on = 1'b1;
    wait_cyc(20);
    chk("R1 after reset, pin inserted", 3'b000);

    cur_req = "R2";
    rbf_pin = 1'b0; wait_cyc(3); rbf_pin = 1'b1;
    wait_cyc(N + 100);
    chk("R2 short removal ignored", 3'b000);

    cur_req = "R4";
    rbf_pin = 1'b0;
    wait_cyc(10); ext_tmr_a = 1'b1;
    wait_cyc(N / 2);
    chk("R8 off during countdown", 3'b000);
    wait_cyc(N + 5 - 10 - N / 2);
    chk("R4 not yet released", 3'b000);
    wait_cyc(15);
    chk("R4 released after internal plus one outside", 3'b111);
    chk("R5 all three on", 3'b111);

    cur_req = "R8";
    ext_tmr_a = 1'b0;
    wait_cyc(40);
    chk("R8 held after outside timer drops", 3'b111);

    cur_req = "R9";
    wdt_rst_n = 1'b0; wait_cyc(5);
    chk("R9 on during watchdog reset", 3'b111);
    wdt_rst_n = 1'b1; wait_cyc(50);
    chk("R9 on after watchdog reset", 3'b111);

    cur_req = "R2";
    rbf_pin = 1'b1; wait_cyc(3); rbf_pin = 1'b0;
    wait_cyc(30);
    chk("R2 short insertion ignored", 3'b111);

    cur_req = "R6";
    rbf_pin = 1'b1; wait_cyc(20);
    chk("R6 insertion clears", 3'b000);
    ext_tmr_a = 1'b1; ext_tmr_b = 1'b1; wait_cyc(20);
    chk("R6 votes ignored while inserted", 3'b000);

    cur_req = "R10";
    rbf_pin = 1'b0; wait_cyc(30);
    chk("R10 two outside timers release early", 3'b111);

    cur_req = "R7";
    ext_tmr_b = 1'b0;
    rbf_pin = 1'b1; wait_cyc(20);
    chk("R6 insertion clears again", 3'b000);
    rbf_pin = 1'b0; wait_cyc(N / 2);
    rbf_pin = 1'b1; wait_cyc(30);
    chk("R7 re-insertion mid countdown", 3'b000);
    rbf_pin = 1'b0;
    wait_cyc(N + 5);
    chk("R7 countdown restarted from zero", 3'b000);
    wait_cyc(15);
    chk("R7 release after full restarted count", 3'b111);

    cur_req = "R9";
    por_n = 1'b0; wait_cyc(3);
    chk("R9 power-on reset clears", 3'b000);
    ext_tmr_a = 1'b0;
    por_n = 1'b1; wait_cyc(20);
    chk("R1 off after power-on with pin out", 3'b000);

    cur_req = "R3";
    wait_cyc(2 * N);
    chk("R3 internal expiry alone no release", 3'b000);
    ext_tmr_b = 1'b1; wait_cyc(20);
    chk("R3 internal plus second outside releases", 3'b111);

    wait_cyc(5);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule